// File: doc/BRIEF.md
# Address Register Load/Store Sequencer

This block is the write path for the eight address registers of a CPU whose data words are 60 bits wide. Each address register holds an 18-bit word address. Writing an address register also starts a memory side effect, and the register index selects that effect. Index 0 only updates the register. Indices 1 to 5 load the memory word at the new address, and the result goes back to the caller tagged with the same index so that it can be steered into the matching data register. Indices 6 and 7 store a 60-bit data value, which the caller supplies with the write, to the new address.

The memory behind the block has a 32-bit data path. Each 60-bit word therefore fills two consecutive 32-bit locations. The upper half of the word, bits 59..30, goes to the even location 2·A. The lower half, bits 29..0, goes to the odd location 2·A+1. In both locations the 30-bit half sits in bits 31..2. The block issues the two beats in order over a valid/ready port whose read data arrives one cycle after the read is accepted, and it holds busy while an access is in flight.

A programmable limit register defines the highest legal word address. Any write to index 1 to 7 is still written into the register file. If its address is above the limit, the memory access is suppressed and a sticky error flag halts the block until reset.

Top module: `areg_ldst_seq`

## Requirements
- R1: A write is accepted when wr_en is high, busy is low and err is low. In the following cycle the register named by wr_idx holds wr_addr, and the combinational read port (rd_idx to rd_addr) returns it.
- R2: An accepted write to index 0 makes no memory request and never raises busy or err.
- R3: An accepted write to index 1..5 with a legal address reads location 2·A first and then 2·A+1. It then pulses ld_valid for one cycle with ld_idx equal to the index and ld_data = {even[31:2], odd[31:2]}. Bits 1..0 of both memory words are ignored.
- R4: An accepted write to index 6 or 7 with a legal address writes {st_data[59:30],2'b00} to location 2·A and then {st_data[29:0],2'b00} to location 2·A+1. This takes exactly two memory beats.
- R5: busy is high from the cycle after a load or store is accepted until its last beat completes. wr_en is ignored while busy is high.
- R6: While mem_valid is high and mem_ready is low, mem_valid, mem_addr, mem_we and mem_wdata stay unchanged in the next cycle.
- R7: The limit register is loaded by lim_we/lim_val and resets to all ones. An accepted write to index 1..7 whose address is greater than the limit sets err in the next cycle and makes no memory request, but it still updates the register.
- R8: err stays set until reset, and while it is set every write request is ignored.
- R9: After reset all address registers read 0, and busy, err, mem_valid and ld_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Address register write request |
| wr_idx | input | 3 | Register index to write |
| wr_addr | input | AW | New word address |
| st_data | input | 60 | Data word stored by an index 6/7 write |
| lim_we | input | 1 | Load the address limit |
| lim_val | input | AW | Highest legal word address |
| rd_idx | input | 3 | Register read select |
| rd_addr | output | AW | Selected register contents |
| busy | output | 1 | Memory access in progress |
| err | output | 1 | Sticky out-of-range halt |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW+1 | 32-bit location address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after an accepted read |
| ld_valid | output | 1 | Load result pulse |
| ld_idx | output | 3 | Data register the result belongs to |
| ld_data | output | 60 | Loaded 60-bit word |

## Verification
The bench builds the block with AW=6, so the whole 64-word address space and its 128 memory locations fit in a bench array. This lets every word address be swept as a store, a load and, above a limit of 40, an out-of-range write. Both the legal side and the error side of the limit are therefore covered at every address, including the boundary at 40/41. A mem_ready pattern that stalls one cycle in three makes the two beats wait at different points of the handshake.

// File: rtl/areg_pkg.sv
package areg_pkg;

    localparam int HALF_W = 30;
    localparam int WORD_W = 2 * HALF_W;
    localparam int BUS_W  = 32;
    localparam int PAD_W  = BUS_W - HALF_W;
    localparam int IDX_W  = 3;
    localparam int NREG   = 1 << IDX_W;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_HI,
        SQ_HI_WAIT,
        SQ_LO,
        SQ_LO_WAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        SE_NONE,
        SE_LOAD,
        SE_STORE
    } side_kind_e;

    function automatic side_kind_e kind_of(input logic [IDX_W-1:0] idx);
        if (idx == '0)
            return SE_NONE;
        else if (idx >= IDX_W'(6))
            return SE_STORE;
        else
            return SE_LOAD;
    endfunction

    function automatic logic [BUS_W-1:0] pack_half(input logic [HALF_W-1:0] h);
        return {h, {PAD_W{1'b0}}};
    endfunction

    function automatic logic [HALF_W-1:0] unpack_half(input logic [BUS_W-1:0] w);
        return w[BUS_W-1:PAD_W];
    endfunction

endpackage

// File: rtl/areg_file.sv
module areg_file
    import areg_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [AW-1:0]    wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [AW-1:0]    rdata
);

    logic [AW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && widx == IDX_W'(g))
                regs[g] <= wdata;
        end
    end

    assign rdata = regs[ridx];

endmodule

// File: rtl/areg_bound.sv
module areg_bound #(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lim_we,
    input  logic [AW-1:0] lim_val,
    input  logic          chk_en,
    input  logic [AW-1:0] chk_addr,
    output logic          in_range,
    output logic          err
);

    logic [AW-1:0] lim_q;

    always_ff @(posedge clk) begin
        if (rst)
            lim_q <= '1;
        else if (lim_we)
            lim_q <= lim_val;
    end

    assign in_range = (chk_addr <= lim_q);

    always_ff @(posedge clk) begin
        if (rst)
            err <= 1'b0;
        else if (chk_en && !in_range)
            err <= 1'b1;
    end

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

// File: rtl/areg_mem_seq.sv
module areg_mem_seq
    import areg_pkg::*;
#(
    parameter int AW = 18,
    localparam int MAW = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  side_kind_e        kind,
    input  logic [IDX_W-1:0]  idx,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] sdata,
    output logic              busy,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [MAW-1:0]    mem_addr,
    output logic [BUS_W-1:0]  mem_wdata,
    input  logic [BUS_W-1:0]  mem_rdata,
    output logic              ld_valid,
    output logic [IDX_W-1:0]  ld_idx,
    output logic [WORD_W-1:0] ld_data
);

    seq_state_e        st_q;
    logic              is_store_q;
    logic [IDX_W-1:0]  idx_q;
    logic [AW-1:0]     base_q;
    logic [WORD_W-1:0] sd_q;
    logic [HALF_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= SQ_IDLE;
            is_store_q <= 1'b0;
            idx_q      <= '0;
            base_q     <= '0;
            sd_q       <= '0;
            hi_q       <= '0;
            ld_valid   <= 1'b0;
            ld_idx     <= '0;
            ld_data    <= '0;
        end else begin
            ld_valid <= 1'b0;
            unique case (st_q)
                SQ_IDLE: begin
                    if (start && kind != SE_NONE) begin
                        is_store_q <= (kind == SE_STORE);
                        idx_q      <= idx;
                        base_q     <= addr;
                        sd_q       <= sdata;
                        st_q       <= SQ_HI;
                    end
                end
                SQ_HI: begin
                    if (mem_ready)
                        st_q <= is_store_q ? SQ_LO : SQ_HI_WAIT;
                end
                SQ_HI_WAIT: begin
                    hi_q <= unpack_half(mem_rdata);
                    st_q <= SQ_LO;
                end
                SQ_LO: begin
                    if (mem_ready)
                        st_q <= is_store_q ? SQ_IDLE : SQ_LO_WAIT;
                end
                SQ_LO_WAIT: begin
                    ld_data  <= {hi_q, unpack_half(mem_rdata)};
                    ld_idx   <= idx_q;
                    ld_valid <= 1'b1;
                    st_q     <= SQ_IDLE;
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy      = (st_q != SQ_IDLE);
    assign mem_valid = (st_q == SQ_HI) || (st_q == SQ_LO);
    assign mem_we    = is_store_q;
    assign mem_addr  = {base_q, (st_q == SQ_LO)};
    assign mem_wdata = (st_q == SQ_LO) ? pack_half(sd_q[HALF_W-1:0])
                                       : pack_half(sd_q[WORD_W-1:HALF_W]);

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_we) && $stable(mem_wdata)));

    assert_ld_index_R3: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> (ld_idx != '0 && ld_idx < IDX_W'(6)));

endmodule

// File: rtl/areg_ldst_seq.sv
module areg_ldst_seq
    import areg_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_idx,
    input  logic [AW-1:0]     wr_addr,
    input  logic [59:0]       st_data,
    input  logic              lim_we,
    input  logic [AW-1:0]     lim_val,
    input  logic [2:0]        rd_idx,
    output logic [AW-1:0]     rd_addr,
    output logic              busy,
    output logic              err,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [AW:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              ld_valid,
    output logic [2:0]        ld_idx,
    output logic [59:0]       ld_data
);

    side_kind_e req_kind;
    logic       accept;
    logic       in_range;
    logic       chk_en;
    logic       start;

    assign req_kind = kind_of(wr_idx);
    assign accept   = wr_en && !busy && !err;
    assign chk_en   = accept && (req_kind != SE_NONE);
    assign start    = chk_en && in_range;

    areg_file #(.AW(AW)) regs_i (
        .clk   (clk),
        .rst   (rst),
        .we    (accept),
        .widx  (wr_idx),
        .wdata (wr_addr),
        .ridx  (rd_idx),
        .rdata (rd_addr)
    );

    areg_bound #(.AW(AW)) bound_i (
        .clk      (clk),
        .rst      (rst),
        .lim_we   (lim_we),
        .lim_val  (lim_val),
        .chk_en   (chk_en),
        .chk_addr (wr_addr),
        .in_range (in_range),
        .err      (err)
    );

    areg_mem_seq #(.AW(AW)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .kind      (req_kind),
        .idx       (wr_idx),
        .addr      (wr_addr),
        .sdata     (st_data),
        .busy      (busy),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .ld_valid  (ld_valid),
        .ld_idx    (ld_idx),
        .ld_data   (ld_data)
    );

    assert_err_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        err |-> !mem_valid);

    assert_idx0_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && wr_idx == 3'd0) |=> !busy);

    assert_busy_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_en));

endmodule

// File: tb/areg_ldst_seq_tb_top.sv
module areg_ldst_seq_tb_top;

    localparam int AW  = 6;
    localparam int NW  = 1 << AW;
    localparam int LIM = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_idx = '0;
    logic [AW-1:0] wr_addr = '0;
    logic [59:0]   st_data = '0;
    logic          lim_we = 1'b0;
    logic [AW-1:0] lim_val = '0;
    logic [2:0]    rd_idx = '0;
    logic [AW-1:0] rd_addr;
    logic          busy, err, mem_valid, mem_we, ld_valid;
    logic          mem_ready = 1'b1;
    logic [AW:0]   mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic [2:0]    ld_idx;
    logic [59:0]   ld_data;

    int total = 0;
    int bad = 0;
    int beats = 0;
    int cyc = 0;
    logic [AW:0] beat_a0, beat_a1;
    logic [31:0] mem [2*NW];

    logic        ld_seen, busy_seen;
    logic [59:0] ld_cap;
    logic [2:0]  ld_icap;

    always #10 clk = ~clk;

    areg_ldst_seq #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr(wr_addr),
        .st_data(st_data), .lim_we(lim_we), .lim_val(lim_val), .rd_idx(rd_idx),
        .rd_addr(rd_addr), .busy(busy), .err(err), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
        .ld_idx(ld_idx), .ld_data(ld_data)
    );

    // bench memory: one-cycle read latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_valid && mem_ready) begin
            if (beats == 0) beat_a0 <= mem_addr;
            if (beats == 1) beat_a1 <= mem_addr;
            beats <= beats + 1;
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    // stall one cycle in three
    always @(negedge clk) mem_ready <= (cyc % 3) != 0;

    function automatic logic [59:0] patt(input int a);
        return 60'h0F1E2D3C4B5A697 ^ (60'(a) * 60'h0000_0A5A_5A5A_5A5) ^ (60'(a) << 52);
    endfunction

    function automatic logic [31:0] junk(input int i);
        return 32'hC0DE_0003 ^ (32'(i) << 8);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_lim(input int v);
        @(negedge clk);
        lim_we = 1'b1;
        lim_val = AW'(v);
        @(negedge clk);
        lim_we = 1'b0;
    endtask

    task automatic do_write(input int idx, input int a, input logic [59:0] d);
        ld_seen = 1'b0;
        busy_seen = 1'b0;
        @(negedge clk);
        wr_en = 1'b1;
        wr_idx = 3'(idx);
        wr_addr = AW'(a);
        st_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        st_data = '0;
        forever begin
            if (busy) busy_seen = 1'b1;
            if (ld_valid) begin
                ld_seen = 1'b1;
                ld_cap = ld_data;
                ld_icap = ld_idx;
            end
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic read_reg(input int idx, output logic [AW-1:0] v);
        rd_idx = 3'(idx);
        #1;
        v = rd_addr;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] rv;
        for (int i = 0; i < 2*NW; i++) mem[i] = junk(i);
        do_reset();

        // R9: reset state
        @(negedge clk);
        chk(!busy && !err && !mem_valid && !ld_valid, "R9 outputs",
            {busy, err, mem_valid, ld_valid}, 0);
        for (int r = 0; r < 8; r++) begin
            read_reg(r, rv);
            chk(rv == 0, "R9 register", rv, 0);
        end

        // R2: index 0 only updates the register
        beats = 0;
        do_write(0, 13, '0);
        read_reg(0, rv);
        chk(rv == 13, "R1 reg0 write", rv, 13);
        chk(!busy_seen && beats == 0 && !err, "R2 no access", beats, 0);

        // R7: limit resets to all ones, top address legal
        do_write(7, NW-1, patt(NW-1));
        chk(!err && beats == 2, "R7 reset limit", {err, 32'(beats)}, 2);
        chk(mem[2*(NW-1)+1] == {patt(NW-1)[29:0], 2'b00}, "R4 top address odd",
            mem[2*(NW-1)+1], {patt(NW-1)[29:0], 2'b00});

        // R5: write while busy is ignored
        do_reset();
        beats = 0;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd6; wr_addr = AW'(3); st_data = patt(3);
        @(negedge clk);
        chk(busy, "R5 busy after accept", busy, 1);
        wr_idx = 3'd4; wr_addr = AW'(9);
        @(negedge clk);
        wr_en = 1'b0;
        while (busy) @(negedge clk);
        read_reg(4, rv);
        chk(rv == 0, "R5 ignored write", rv, 0);
        chk(beats == 2, "R5 beat count", beats, 2);
        for (int i = 0; i < 2*NW; i++) mem[i] = junk(i);

        // sweep every word address
        for (int a = 0; a < NW; a++) begin
            int sidx, lidx;
            sidx = 6 + (a % 2);
            lidx = 1 + (a % 5);
            do_reset();
            set_lim(LIM);
            beats = 0;
            do_write(sidx, a, patt(a));
            read_reg(sidx, rv);
            chk(rv == AW'(a), "R1 store reg value", rv, a);
            if (a <= LIM) begin
                chk(!err && beats == 2, "R4 two beats", {err, 32'(beats)}, 2);
                chk(beat_a0 == (AW+1)'(2*a) && beat_a1 == (AW+1)'(2*a+1), "R4 beat order",
                    {beat_a0, beat_a1}, {(AW+1)'(2*a), (AW+1)'(2*a+1)});
                chk(mem[2*a] == {patt(a)[59:30], 2'b00}, "R4 even word",
                    mem[2*a], {patt(a)[59:30], 2'b00});
                chk(mem[2*a+1] == {patt(a)[29:0], 2'b00}, "R4 odd word",
                    mem[2*a+1], {patt(a)[29:0], 2'b00});
                mem[2*a][1:0] = 2'b01;
                mem[2*a+1][1:0] = 2'b10;
                beats = 0;
                do_write(lidx, a, '0);
                chk(beats == 2 && beat_a0 == (AW+1)'(2*a) && beat_a1 == (AW+1)'(2*a+1),
                    "R3 read order", {beat_a0, beat_a1}, {(AW+1)'(2*a), (AW+1)'(2*a+1)});
                chk(ld_seen && ld_cap == patt(a), "R3 load data", ld_cap, patt(a));
                chk(ld_icap == 3'(lidx), "R3 load index", ld_icap, lidx);
                chk(busy_seen, "R5 busy during load", busy_seen, 1);
            end else begin
                chk(err, "R7 out of range err", err, 1);
                chk(beats == 0 && !busy_seen, "R7 access suppressed", beats, 0);
                chk(mem[2*a] == junk(2*a) && mem[2*a+1] == junk(2*a+1), "R7 memory intact",
                    mem[2*a], junk(2*a));
                do_write(0, a ^ 5, '0);
                read_reg(0, rv);
                chk(rv == 0 && err, "R8 halted write ignored", rv, 0);
                do_write(2, 1, '0);
                chk(beats == 0 && !ld_seen, "R8 halted load ignored", beats, 0);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule